// File: doc/BRIEF.md
# Down-Counting Interval Timer

This block is a single-channel 32-bit interval timer behind an APB slave port. Software programs a reload value and a three-bit control word; while enabled, the counter steps down by one on every cycle where the tick strobe is high. When a tick arrives with the count at zero, the counter reloads and latches an interrupt. The reload value is the programmed value in periodic mode, or all ones in free-running mode. Free-running mode gives the longest possible period and, with the count read back and inverted, an up-counting time base.

The interrupt stays latched until software reads one of the two clear offsets. A mask bit hides the interrupt from the output pin and the masked status view, but not from the raw view. A fixed version word identifies the block. The tick strobe is synchronous to the bus clock, so no clock crossing is involved.

Top module: `tick_timer`

## Requirements
- R1: After reset, the reload value (0x00), the count (0x04) and the control word (0x08) all read as zero, and irq_o is low.
- R2: pready_o is always 1 and pslverr_o is always 0. Writes to read-only offsets (0x04, 0x10, 0xA0, 0xA8, 0xAC) change nothing. Reads of unmapped offsets return zero. The control word keeps only bits [2:0] (bit 0 enable, bit 1 periodic, bit 2 mask) and reads back zero-extended.
- R3: When a control write sets enable while it was clear, the first tick loads the count from the reload register. Each later tick lowers the count by one. Cycles without a tick leave the count unchanged.
- R4: In periodic mode (bit 1 = 1), a tick with the count at zero reloads the count from the reload register and sets the raw interrupt. A reload value of N therefore gives an interrupt every N+1 ticks.
- R5: In free-running mode (bit 1 = 0), a tick with the count at zero reloads 0xFFFF_FFFF and sets the raw interrupt.
- R6: While enable is clear, the count holds its value whatever the ticks do, and the raw interrupt bit keeps its value.
- R7: The raw interrupt (bit 0 at 0xA8) ignores the mask. The masked status (bit 0 at 0x10 and at 0xA0) and irq_o equal raw AND NOT mask.
- R8: A read at 0x0C or 0xA4 returns zero and clears the raw interrupt. A write to either offset has no effect.
- R9: Offset 0xAC returns the VERSION parameter (default 0x3230_312A).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and timer clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write strobe |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | DATA_W | APB write data |
| prdata_o | output | DATA_W | APB read data |
| pready_o | output | 1 | APB ready, constant 1 |
| pslverr_o | output | 1 | APB error, constant 0 |
| tick_i | input | 1 | Count strobe, one count per high cycle |
| irq_o | output | 1 | Masked interrupt, active high |

## Verification
The bench checks the off-by-one period. A design that reloads when the count reaches one instead of on the tick at zero would raise the interrupt one tick early. It checks the first tick after enabling: a design that skips that load would decrement a stale count. It also runs a zero reload in free-running mode, where a design with the wrong mode sense would wrap to the reload value instead of all ones. The other checks cover masking: a design that gates the raw bit with the mask would hide it at 0xA8. They cover clearing on a read of either clear offset, where writes must do nothing. Last, they cover freezing while disabled, where a design that clears the latched interrupt or keeps counting would be caught by readback.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam logic [7:0] OFF_LOAD  = 8'h00;
  localparam logic [7:0] OFF_COUNT = 8'h04;
  localparam logic [7:0] OFF_CTRL  = 8'h08;
  localparam logic [7:0] OFF_CLR   = 8'h0C;
  localparam logic [7:0] OFF_STAT  = 8'h10;
  localparam logic [7:0] OFF_GSTAT = 8'hA0;
  localparam logic [7:0] OFF_GCLR  = 8'hA4;
  localparam logic [7:0] OFF_GRAW  = 8'hA8;
  localparam logic [7:0] OFF_VER   = 8'hAC;

  typedef struct packed {
    logic mask;
    logic periodic;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter logic [31:0] VERSION = 32'h3230_312A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  input  logic [DATA_W-1:0] count_i,
  input  logic              raw_i,
  output ctrl_t             ctrl_o,
  output logic [DATA_W-1:0] load_o,
  output logic              start_o,
  output logic              stop_o,
  output logic              clr_o
);
  localparam int unsigned CTRL_W = $bits(ctrl_t);

  logic        acc, wr, rd;
  logic [7:0]  off;
  logic        masked;
  ctrl_t       ctrl_q;
  logic [DATA_W-1:0] load_q;

  assign off    = paddr_i[7:0];
  assign acc    = psel_i & penable_i;
  assign wr     = acc & pwrite_i;
  assign rd     = acc & ~pwrite_i;
  assign masked = raw_i & ~ctrl_q.mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '0;
    end else if (wr) begin
      if (off == OFF_CTRL) ctrl_q <= ctrl_t'(pwdata_i[CTRL_W-1:0]);
      if (off == OFF_LOAD) load_q <= pwdata_i;
    end
  end

  // enable rising edge arms the first-tick load
  assign start_o = wr && (off == OFF_CTRL) && pwdata_i[0] && !ctrl_q.en;
  assign stop_o  = wr && (off == OFF_CTRL) && !pwdata_i[0];
  assign clr_o   = rd && ((off == OFF_CLR) || (off == OFF_GCLR));

  always_comb begin
    prdata_o = '0;
    unique case (off)
      OFF_LOAD:             prdata_o = load_q;
      OFF_COUNT:            prdata_o = count_i;
      OFF_CTRL:             prdata_o[CTRL_W-1:0] = ctrl_q;
      OFF_STAT, OFF_GSTAT:  prdata_o[0] = masked;
      OFF_GRAW:             prdata_o[0] = raw_i;
      OFF_VER:              prdata_o = DATA_W'(VERSION);
      default:              prdata_o = '0;
    endcase
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;
endmodule

// File: rtl/tick_timer_counter.sv
module tick_timer_counter #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              en_i,
  input  logic              periodic_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] count_o,
  output logic              pend_o,
  output logic              raw_o
);
  logic [DATA_W-1:0] cnt_q;
  logic              pend_q, raw_q;
  logic              step, wrap;

  assign step = en_i & tick_i;
  assign wrap = step & ~pend_q & (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (start_i)     pend_q <= 1'b1;
      else if (stop_i) pend_q <= 1'b0;
      if (step) begin
        if (pend_q) begin
          cnt_q  <= load_i;
          pend_q <= 1'b0;
        end else if (wrap) begin
          cnt_q <= periodic_i ? load_i : '1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    raw_q <= 1'b0;
    else if (wrap)  raw_q <= 1'b1;
    else if (clr_i) raw_q <= 1'b0;
  end

  assign count_o = cnt_q;
  assign pend_o  = pend_q;
  assign raw_o   = raw_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned DATA_W  = 32,
  parameter logic [31:0] VERSION = 32'h3230_312A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  input  logic              tick_i,
  output logic              irq_o
);
  ctrl_t             ctrl;
  logic [DATA_W-1:0] load_q, count;
  logic              start, stop, clr_rd, raw, pend;
  logic              ctrl_en, ctrl_per, ctrl_mask;

  assign ctrl_en   = ctrl.en;
  assign ctrl_per  = ctrl.periodic;
  assign ctrl_mask = ctrl.mask;

  tick_timer_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .VERSION(VERSION)
  ) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .psel_i   (psel_i),
    .penable_i(penable_i),
    .pwrite_i (pwrite_i),
    .paddr_i  (paddr_i),
    .pwdata_i (pwdata_i),
    .prdata_o (prdata_o),
    .count_i  (count),
    .raw_i    (raw),
    .ctrl_o   (ctrl),
    .load_o   (load_q),
    .start_o  (start),
    .stop_o   (stop),
    .clr_o    (clr_rd)
  );

  tick_timer_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .en_i      (ctrl_en),
    .periodic_i(ctrl_per),
    .load_i    (load_q),
    .start_i   (start),
    .stop_i    (stop),
    .clr_i     (clr_rd),
    .count_o   (count),
    .pend_o    (pend),
    .raw_o     (raw)
  );

  assign irq_o     = raw & ~ctrl_mask;
  assign pready_o  = 1'b1;
  assign pslverr_o = 1'b0;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              en,
  input logic              per,
  input logic              mask,
  input logic              pend,
  input logic              clr,
  input logic              raw,
  input logic              irq,
  input logic              rdy,
  input logic              err,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] load
);
  logic wrap_c;
  assign wrap_c = en && tick_i && !pend && (count == '0);

  assert_bus_ok_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdy && !err);
  assert_first_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && tick_i && pend) |=> count == $past(load));
  assert_per_reload_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_c && per) |=> (count == $past(load)) && raw);
  assert_free_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_c && !per) |=> (count == '1) && raw);
  assert_freeze_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en && !clr) |=> $stable(count) && $stable(raw));
  assert_irq_mask_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (raw && !mask) |-> irq);
  assert_masked_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask |-> !irq);
  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr && !wrap_c) |=> !raw);
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .tick_i(tick_i),
  .en    (ctrl_en),
  .per   (ctrl_per),
  .mask  (ctrl_mask),
  .pend  (pend),
  .clr   (clr_rd),
  .raw   (raw),
  .irq   (irq_o),
  .rdy   (pready_o),
  .err   (pslverr_o),
  .count (count),
  .load  (load_q)
);

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, tick = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr, irq;
  int          n_chk = 0, n_fail = 0;
  logic        done = 1'b0;

  always #4 clk = ~clk;

  tick_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .tick_i(tick), .irq_o(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic restart(input logic [31:0] ld, input logic [31:0] c);
    wr(8'h08, 32'h0);
    wr(8'h00, ld);
    wr(8'h08, c);
  endtask

  task automatic t_reset;
    rd_chk("R1 load", 8'h00, 0);
    rd_chk("R1 count", 8'h04, 0);
    rd_chk("R1 ctrl", 8'h08, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R2 ready/err", {30'b0, pready, pslverr}, 32'h2);
  endtask

  task automatic t_periodic;
    restart(5, 3);
    rd_chk("R3 no tick yet", 8'h04, 0);
    ticks(1); rd_chk("R3 first tick loads", 8'h04, 5);
    ticks(2); rd_chk("R3 decrement", 8'h04, 3);
    repeat (5) @(negedge clk);
    rd_chk("R3 idle holds", 8'h04, 3);
    ticks(3); rd_chk("R4 at zero", 8'h04, 0);
    rd_chk("R4 no irq before wrap", 8'h10, 0);
    ticks(1); rd_chk("R4 reload", 8'h04, 5);
    check("R4 irq", {31'b0, irq}, 1);
    rd_chk("R7 raw", 8'hA8, 1);
    rd_chk("R7 stat", 8'h10, 1);
    rd_chk("R7 gstat", 8'hA0, 1);
  endtask

  task automatic t_clear;
    rd_chk("R8 clr reads zero", 8'h0C, 0);
    check("R8 irq cleared", {31'b0, irq}, 0);
    rd_chk("R8 raw cleared", 8'hA8, 0);
    ticks(6); rd_chk("R4 second wrap", 8'hA8, 1);
    wr(8'h0C, 32'hFFFF_FFFF); wr(8'hA4, 32'h1);
    rd_chk("R8 write no effect", 8'hA8, 1);
    rd_chk("R8 gclr reads zero", 8'hA4, 0);
    rd_chk("R8 gclr clears", 8'hA8, 0);
  endtask

  task automatic t_mask;
    restart(5, 7);
    ticks(7);
    rd_chk("R7 raw ignores mask", 8'hA8, 1);
    rd_chk("R7 stat masked", 8'h10, 0);
    rd_chk("R7 gstat masked", 8'hA0, 0);
    check("R7 irq masked", {31'b0, irq}, 0);
    wr(8'h08, 3);
    @(negedge clk); check("R7 irq unmasked", {31'b0, irq}, 1);
    rd_chk("R8 clear", 8'h0C, 0);
  endtask

  task automatic t_disable;
    restart(2, 3);
    ticks(1); rd_chk("R3 load 2", 8'h04, 2);
    ticks(3); rd_chk("R4 period 3", 8'h04, 2);
    ticks(1);
    wr(8'h08, 2);
    ticks(4);
    rd_chk("R6 count frozen", 8'h04, 1);
    rd_chk("R6 raw held", 8'hA8, 1);
    rd_chk("R8 clear", 8'hA4, 0);
  endtask

  task automatic t_free;
    restart(0, 1);
    ticks(1); rd_chk("R3 load 0", 8'h04, 0);
    check("R5 no irq yet", {31'b0, irq}, 0);
    ticks(1); rd_chk("R5 wrap all ones", 8'h04, 32'hFFFF_FFFF);
    check("R5 irq", {31'b0, irq}, 1);
    ticks(1); rd_chk("R5 decrement", 8'h04, 32'hFFFF_FFFE);
    rd_chk("R8 clear", 8'h0C, 0);
  endtask

  task automatic t_map;
    wr(8'h08, 0);
    wr(8'h04, 32'h1234);
    rd_chk("R2 count ro", 8'h04, 32'hFFFF_FFFE);
    wr(8'hA8, 1); wr(8'hAC, 0);
    rd_chk("R2 raw ro", 8'hA8, 0);
    rd_chk("R9 version", 8'hAC, 32'h3230_312A);
    rd_chk("R2 unmapped 0x14", 8'h14, 0);
    rd_chk("R2 unmapped 0x40", 8'h40, 0);
    wr(8'h08, 32'hFFFF_FFFA);
    rd_chk("R2 ctrl width", 8'h08, 2);
    check("R2 ready/err", {30'b0, pready, pslverr}, 32'h2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset;
    t_periodic;
    t_clear;
    t_mask;
    t_disable;
    t_free;
    t_map;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule